// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This block is a 32-bit arithmetic stage for a datapath that must never wrap silently. Each operation is started by a one-cycle strobe together with two operands, a 4-bit operation code and a 5-bit saturation width. One clock edge later, a registered result appears with a valid pulse. Several kinds of clamping are supported:

- signed and unsigned add and subtract that clamp at the range limits;
- a signed doubling that clamps;
- clamping of a whole word to a chosen bit count, signed or unsigned;
- the same clamping applied separately to each 16-bit half;
- an add that wraps normally but still reports signed overflow.

Every clamp, and every overflow of the reporting add, raises a sticky overflow flag. No arithmetic operation lowers this flag. Only a dedicated clear input or reset returns it to zero, so software can run a whole sequence and then inspect a single bit.

Top module: `sat_alu`

## Requirements
- R1: Operation code 0 (signed add) and code 1 (signed subtract) return the wrapped result when there is no signed overflow. When signed overflow occurs, the result is 0x7FFFFFFF if operand A is non-negative and 0x80000000 if A is negative, and the overflow flag is set.
- R2: Code 2 (unsigned add) returns 0xFFFFFFFF and sets the flag when A+B carries out of 32 bits. Code 3 (unsigned subtract) returns 0 and sets the flag when B exceeds A. Otherwise both return the plain sum or difference.
- R3: Code 4 (doubling of A) returns 0x7FFFFFFF when A, taken as signed, is at least 0x40000000. It returns 0x80000000 when A is at most 0xC0000000 as a signed value. In both of those cases the flag is set. Otherwise it returns A shifted left by one with no flag.
- R4: Code 5 (signed word clamp with width n = amount input) limits A to the range -(2^n) to 2^n-1. It returns A unchanged inside that range, and it sets the flag when it clamps.
- R5: Code 6 (unsigned word clamp) returns 0 for negative A and 2^n-1 for A above 2^n-1, setting the flag in both cases. Otherwise it returns A unchanged.
- R6: Code 7 (signed) and code 8 (unsigned) apply the R4 and R5 clamp separately to the sign-extended low half A[15:0] and the sign-extended high half A[31:16]. Each clamped value is truncated to 16 bits and placed back in its own half. The flag is set if either half clamps.
- R7: Code 9 returns the wrapped sum A+B. It sets the flag on signed overflow, using the R1 condition.
- R8: The overflow flag is sticky. It stays at 1 through any number of operations that do not clamp.
- R9: A high clear input drops the flag to 0 on the next clock edge. If a clamping operation is started in the same cycle, the flag ends at 1.
- R10: The valid output is high exactly in the cycle after a start strobe. The result and flag are updated on the same edge. The result holds its value while no start is given.
- R11: While reset is low, the result, the valid output and the flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Starts an operation this cycle |
| op_i | input | 4 | Operation code (see R1 to R7) |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| amt_i | input | 5 | Saturation width n for the clamp operations |
| clr_q_i | input | 1 | Synchronous clear of the overflow flag |
| res_o | output | 32 | Registered result |
| valid_o | output | 1 | High one cycle after start_i |
| q_o | output | 1 | Sticky overflow flag |

## Verification
Every result, its valid pulse and any rise of the flag are due exactly one clock edge after the cycle in which the start strobe is sampled. A clear is likewise visible one edge after it is sampled. The bench drives each input on a falling edge, releases the strobe on the next falling edge, and reads the outputs at that same moment, which falls half a period after the capturing edge. For the hold and valid-drop checks, it then waits one or more further falling edges before reading again.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  localparam int DW = 32;
  localparam int AMTW = 5;
  localparam int OPW = 4;
  localparam int LANES = 2;
  localparam int LW = DW / LANES;

  typedef enum logic [OPW-1:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_UADD   = 4'd2,
    OP_USUB   = 4'd3,
    OP_DBL    = 4'd4,
    OP_SCLAMP = 4'd5,
    OP_UCLAMP = 4'd6,
    OP_SCL16  = 4'd7,
    OP_UCL16  = 4'd8,
    OP_ADDFLG = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           hit_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QTR  = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] NQTR = {2'b11, {(W-2){1'b0}}};

  logic [W:0]   sum_x;
  logic [W:0]   dif_x;
  logic         s_add_ovf;
  logic         s_sub_ovf;
  logic [W-1:0] edge_val;

  always_comb begin
    sum_x     = {1'b0, a_i} + {1'b0, b_i};
    dif_x     = {1'b0, a_i} - {1'b0, b_i};
    s_add_ovf = (a_i[W-1] == b_i[W-1]) && (sum_x[W-1] != a_i[W-1]);
    s_sub_ovf = (a_i[W-1] != b_i[W-1]) && (dif_x[W-1] != a_i[W-1]);
    edge_val  = a_i[W-1] ? SMIN : SMAX;
    res_o     = '0;
    hit_o     = 1'b0;
    case (op_i)
      OP_SADD: begin
        res_o = s_add_ovf ? edge_val : sum_x[W-1:0];
        hit_o = s_add_ovf;
      end
      OP_SSUB: begin
        res_o = s_sub_ovf ? edge_val : dif_x[W-1:0];
        hit_o = s_sub_ovf;
      end
      OP_UADD: begin
        res_o = sum_x[W] ? '1 : sum_x[W-1:0];
        hit_o = sum_x[W];
      end
      OP_USUB: begin
        res_o = dif_x[W] ? '0 : dif_x[W-1:0];
        hit_o = dif_x[W];
      end
      OP_DBL: begin
        if ($signed(a_i) >= $signed(QTR)) begin
          res_o = SMAX;
          hit_o = 1'b1;
        end else if ($signed(a_i) <= $signed(NQTR)) begin
          res_o = SMIN;
          hit_o = 1'b1;
        end else begin
          res_o = {a_i[W-2:0], 1'b0};
        end
      end
      OP_ADDFLG: begin
        res_o = sum_x[W-1:0];
        hit_o = s_add_ovf;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W = 32,
  parameter int AW = 5
) (
  input  logic [W-1:0]  val_i,
  input  logic [AW-1:0] amt_i,
  input  logic          uns_i,
  output logic [W-1:0]  res_o,
  output logic          hit_o
);
  logic signed [W-1:0] top;
  logic [W-1:0]        lim;

  always_comb begin
    top   = $signed(val_i) >>> amt_i;
    lim   = ({{(W-1){1'b0}}, 1'b1} << amt_i) - {{(W-1){1'b0}}, 1'b1};
    res_o = val_i;
    hit_o = 1'b0;
    if (uns_i) begin
      if (val_i[W-1]) begin
        res_o = '0;
        hit_o = 1'b1;
      end else if (val_i > lim) begin
        res_o = lim;
        hit_o = 1'b1;
      end
    end else begin
      if (top > 0) begin
        res_o = lim;
        hit_o = 1'b1;
      end else if (top < -1) begin
        res_o = ~lim;
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [AMTW-1:0] amt_i,
  input  logic            clr_q_i,
  output logic [DW-1:0]   res_o,
  output logic            valid_o,
  output logic            q_o
);
  logic [DW-1:0] as_res;
  logic          as_hit;
  logic [DW-1:0] wd_res;
  logic          wd_hit;
  logic [LW-1:0] ln_res [LANES];
  logic [LANES-1:0] ln_hit;
  logic          word_uns;
  logic          lane_uns;

  logic [DW-1:0] res_d, res_q;
  logic          valid_d, valid_q;
  logic          q_d, q_q;
  logic [DW-1:0] pick_res;
  logic          pick_hit;
  logic [DW-1:0] lanes_cat;

  assign word_uns = (op_i == OP_UCLAMP);
  assign lane_uns = (op_i == OP_UCL16);

  sat_addsub #(.W(DW)) u_addsub (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (as_res),
    .hit_o (as_hit)
  );

  sat_clamp #(.W(DW), .AW(AMTW)) u_word (
    .val_i (a_i),
    .amt_i (amt_i),
    .uns_i (word_uns),
    .res_o (wd_res),
    .hit_o (wd_hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sat_clamp #(.W(LW), .AW(AMTW)) u_half (
      .val_i (a_i[g*LW +: LW]),
      .amt_i (amt_i),
      .uns_i (lane_uns),
      .res_o (ln_res[g]),
      .hit_o (ln_hit[g])
    );
    assign lanes_cat[g*LW +: LW] = ln_res[g];
  end

  always_comb begin
    case (op_i)
      OP_SCLAMP, OP_UCLAMP: begin
        pick_res = wd_res;
        pick_hit = wd_hit;
      end
      OP_SCL16, OP_UCL16: begin
        pick_res = lanes_cat;
        pick_hit = |ln_hit;
      end
      default: begin
        pick_res = as_res;
        pick_hit = as_hit;
      end
    endcase
  end

  always_comb begin
    res_d   = res_q;
    valid_d = start_i;
    q_d     = q_q;
    if (clr_q_i) q_d = 1'b0;
    if (start_i) begin
      res_d = pick_res;
      if (pick_hit) q_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      q_q     <= 1'b0;
    end else begin
      valid_q <= valid_d;
      q_q     <= q_d;
      if (start_i) res_q <= res_d;
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;
  assign q_o     = q_q;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
  import sat_alu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [OPW-1:0]  op_i,
  input logic [DW-1:0]   a_i,
  input logic [DW-1:0]   b_i,
  input logic [AMTW-1:0] amt_i,
  input logic            clr_q_i,
  input logic [DW-1:0]   res_o,
  input logic            valid_o,
  input logic            q_o
);
  assert_valid_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(res_o));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_q_i) |=> q_o);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q_i && !start_i) |=> !q_o);
  assert_uadd_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_UADD) |=> (res_o >= $past(a_i)));
  assert_usat_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_UCLAMP) |=>
      (res_o <= ((32'd1 << $past(amt_i)) - 32'd1)));
  assert_addflag_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_ADDFLG) |=> (res_o == $past(a_i) + $past(b_i)));
  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R11: assert (res_o == '0 && !valid_o && !q_o);
    end
  end
endmodule

bind sat_alu sat_alu_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .amt_i   (amt_i),
  .clr_q_i (clr_q_i),
  .res_o   (res_o),
  .valid_o (valid_o),
  .q_o     (q_o)
);

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [3:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic [4:0]  amt_i;
  logic        clr_q_i;
  logic [31:0] res_o;
  logic        valid_o;
  logic        q_o;

  int checks = 0;
  int errors = 0;
  bit qexp = 1'b0;
  bit done = 1'b0;

  sat_alu u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] amt,
                        input logic [31:0] exp_res, input bit exp_hit, input bit clr = 1'b0);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; amt_i = amt; start_i = 1'b1; clr_q_i = clr;
    @(negedge clk);
    start_i = 1'b0; clr_q_i = 1'b0;
    if (clr) qexp = 1'b0;
    if (exp_hit) qexp = 1'b1;
    chk({tag, " result"}, res_o, exp_res);
    chk({tag, " valid"}, {31'd0, valid_o}, 32'd1);
    chk({tag, " flag"}, {31'd0, q_o}, {31'd0, qexp});
  endtask

  task automatic clear_flag();
    @(negedge clk);
    clr_q_i = 1'b1;
    @(negedge clk);
    clr_q_i = 1'b0;
    qexp = 1'b0;
    chk("R9 clear", {31'd0, q_o}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; clr_q_i = 1'b0;
    op_i = '0; a_i = '0; b_i = '0; amt_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset result", res_o, 32'd0);
    chk("R11 reset valid", {31'd0, valid_o}, 32'd0);
    chk("R11 reset flag", {31'd0, q_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_signed_addsub();
    clear_flag();
    run_op("R1 sadd none", 4'd0, 32'd5, 32'd3, 5'd0, 32'd8, 1'b0);
    run_op("R1 sadd pos", 4'd0, 32'h7FFFFFF0, 32'h20, 5'd0, 32'h7FFFFFFF, 1'b1);
    clear_flag();
    run_op("R1 sadd neg", 4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
    clear_flag();
    run_op("R1 ssub none", 4'd1, 32'd10, 32'd20, 5'd0, 32'hFFFFFFF6, 1'b0);
    run_op("R1 ssub neg", 4'd1, 32'h80000000, 32'd1, 5'd0, 32'h80000000, 1'b1);
    run_op("R1 ssub pos", 4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
  endtask

  task automatic t_unsigned_addsub();
    clear_flag();
    run_op("R2 uadd none", 4'd2, 32'd1, 32'd2, 5'd0, 32'd3, 1'b0);
    run_op("R2 usub none", 4'd3, 32'd6, 32'd5, 5'd0, 32'd1, 1'b0);
    run_op("R2 uadd sat", 4'd2, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
    clear_flag();
    run_op("R2 usub sat", 4'd3, 32'd5, 32'd6, 5'd0, 32'd0, 1'b1);
  endtask

  task automatic t_double();
    clear_flag();
    run_op("R3 dbl below", 4'd4, 32'h3FFFFFFF, 32'd0, 5'd0, 32'h7FFFFFFE, 1'b0);
    run_op("R3 dbl above neg", 4'd4, 32'hC0000001, 32'd0, 5'd0, 32'h80000002, 1'b0);
    run_op("R3 dbl top", 4'd4, 32'h40000000, 32'd0, 5'd0, 32'h7FFFFFFF, 1'b1);
    clear_flag();
    run_op("R3 dbl bottom", 4'd4, 32'hC0000000, 32'd0, 5'd0, 32'h80000000, 1'b1);
  endtask

  task automatic t_word_clamp();
    clear_flag();
    run_op("R4 ssat in hi", 4'd5, 32'd127, 32'd0, 5'd7, 32'd127, 1'b0);
    run_op("R4 ssat in lo", 4'd5, 32'hFFFFFF80, 32'd0, 5'd7, 32'hFFFFFF80, 1'b0);
    run_op("R4 ssat high", 4'd5, 32'd200, 32'd0, 5'd7, 32'h7F, 1'b1);
    run_op("R4 ssat low", 4'd5, 32'hFFFFFED4, 32'd0, 5'd7, 32'hFFFFFF80, 1'b1);
    run_op("R4 ssat n0", 4'd5, 32'd5, 32'd0, 5'd0, 32'd0, 1'b1);
    clear_flag();
    run_op("R5 usat in", 4'd6, 32'd255, 32'd0, 5'd8, 32'd255, 1'b0);
    run_op("R5 usat n31", 4'd6, 32'h7FFFFFFF, 32'd0, 5'd31, 32'h7FFFFFFF, 1'b0);
    run_op("R5 usat neg", 4'd6, 32'hFFFFFFFF, 32'd0, 5'd8, 32'd0, 1'b1);
    run_op("R5 usat high", 4'd6, 32'd300, 32'd0, 5'd8, 32'hFF, 1'b1);
  endtask

  task automatic t_half_clamp();
    clear_flag();
    run_op("R6 ssat16 in", 4'd7, 32'h0010FFF0, 32'd0, 5'd7, 32'h0010FFF0, 1'b0);
    run_op("R6 ssat16 n16", 4'd7, 32'h80007FFF, 32'd0, 5'd16, 32'h80007FFF, 1'b0);
    run_op("R6 usat16 in", 4'd8, 32'h7FFF0000, 32'd0, 5'd15, 32'h7FFF0000, 1'b0);
    run_op("R6 ssat16 both", 4'd7, 32'h0100FF00, 32'd0, 5'd7, 32'h007FFF80, 1'b1);
    clear_flag();
    run_op("R6 usat16 hi", 4'd8, 32'h80000005, 32'd0, 5'd4, 32'h00000005, 1'b1);
  endtask

  task automatic t_add_flag();
    clear_flag();
    run_op("R7 addflg none", 4'd9, 32'd2, 32'd3, 5'd0, 32'd5, 1'b0);
    run_op("R7 addflg ovf", 4'd9, 32'h7FFFFFFF, 32'd1, 5'd0, 32'h80000000, 1'b1);
  endtask

  task automatic t_sticky();
    run_op("R8 sticky add", 4'd0, 32'd1, 32'd1, 5'd0, 32'd2, 1'b0);
    run_op("R8 sticky usub", 4'd3, 32'd9, 32'd4, 5'd0, 32'd5, 1'b0);
    chk("R8 flag held", {31'd0, q_o}, 32'd1);
  endtask

  task automatic t_clear_race();
    clear_flag();
    run_op("R9 set wins", 4'd2, 32'hFFFFFFFF, 32'd1, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b1);
    chk("R9 flag after race", {31'd0, q_o}, 32'd1);
    run_op("R9 clear with quiet op", 4'd0, 32'd4, 32'd4, 5'd0, 32'd8, 1'b0, 1'b1);
  endtask

  task automatic t_valid_hold();
    run_op("R10 load", 4'd0, 32'd100, 32'd23, 5'd0, 32'd123, 1'b0);
    @(negedge clk);
    a_i = 32'hDEAD; b_i = 32'hBEEF; op_i = 4'd0;
    chk("R10 valid drops", {31'd0, valid_o}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 result holds", res_o, 32'd123);
    chk("R10 valid stays low", {31'd0, valid_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_signed_addsub();
    t_unsigned_addsub();
    t_double();
    t_word_clamp();
    t_half_clamp();
    t_add_flag();
    t_sticky();
    t_clear_race();
    t_valid_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule